// File: doc/BRIEF.md
# Core Halt and Countdown Stall Control

This block is a single 32-bit control word, one per processor core, that can hold that core's pipeline. The word has two ways to hold the core. In the first, a sleep bit keeps the halt output high until an interrupt arrives. In the second, software programs a cycle count, a start bit and a wait bit. The next instruction the core issues is then held for exactly that many clocks.

Software reaches the word through a small register port: a select, a write enable, write data and read data. The core sends a one-cycle pulse each time it issues an instruction, and it receives a halt level back. While a countdown runs, the low byte reads back the cycles still to go. There are two wait bits. When only one is set, it stays set after the count ends. When both are set, the lower one clears itself at the end of the count. The flag bits in the middle of the word hold whatever software writes to them and change nothing else.

The countdown is run by a small state machine. It has three states:
- `ST_IDLE`: no countdown pending.
- `ST_ARMED`: a valid countdown has been written and is waiting for the next instruction.
- `ST_COUNT`: the issued instruction is being held.

Its transitions are:
- IDLE→ARMED on an arming write.
- ARMED→COUNT on an instruction issue pulse.
- COUNT→IDLE on the last decrement.
- Any state goes to ARMED or IDLE on a write, depending on whether the written value arms.

Top module: `core_halt_ctl`

## Requirements
- R1: After reset the word reads 0x00000000 and halt is low.
- R2: While bit 31 is set, halt stays high, and bit 31 remains set until an interrupt is seen.
- R3: An interrupt pulse while bit 31 is set clears bit 31, and halt falls one clock later unless a countdown holds it.
- R4: A write arms a countdown when bit 27 is 1, bit 30 or bit 29 is 1, and bits [7:0] are non-zero. Halt stays low until the next insn_issue pulse.
- R5: From the clock after that insn_issue pulse, halt is high for exactly N clocks, where N is the written bits [7:0]. Bits [7:0] read back one less on each of those clocks and end at zero.
- R6: When bits 30 and 29 are both set, bit 29 is cleared as the count reaches zero and bit 30 stays set. Writing 0x68000080 and issuing one instruction holds it for 128 clocks, after which the word reads 0x48000000.
- R7: When only one of bits 30 and 29 is set, that bit and bit 27 are still set after the count ends.
- R8: A write with bit 27 clear, with both wait bits clear, or with a zero count arms nothing. A later insn_issue pulse leaves halt low and the word unchanged.
- R9: Bit 28 and bits [26:8] read back exactly as written and have no effect on halt.
- R10: A write always loads the whole word and takes priority over an interrupt or a decrement in the same cycle. Writing zero drops halt on the next clock and stops any countdown.
- R11: rdata shows the word while sel is high and reads 0 while sel is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write enable, acts only when sel is high |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when not selected |
| irq | input | 1 | Interrupt seen by this core |
| insn_issue | input | 1 | One-cycle pulse per instruction issued |
| halt | output | 1 | Hold the core pipeline |

## Verification
A fault in the countdown state would show at the halt pin within one clock of the issue pulse. It appears as a missing stall, an early stall, or a stall one clock too long or too short. A wrong count or wait bit appears on the next read, as a wrong remaining value or a bit 29 that did or did not clear. A missed wake leaves halt high on the clock after the interrupt. The bench compares both pins every clock against a model built from the requirements, so any such divergence is reported in the cycle where it first appears.

// File: rtl/halt_pkg.sv
package halt_pkg;
    localparam int SLEEP_BIT  = 31;
    localparam int WAIT_A_BIT = 30;
    localparam int WAIT_B_BIT = 29;
    localparam int START_BIT  = 27;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2
    } cd_state_e;
endpackage

// File: rtl/halt_cd_fsm.sv
module halt_cd_fsm
    import halt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             arm_wr,
    input  logic             insn_issue,
    input  logic             run_ok,
    input  logic [CNT_W-1:0] cnt,
    output logic             dec,
    output logic             done,
    output logic             stalling
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    cd_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_hit) begin
            state_d = arm_wr ? ST_ARMED : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARMED: if (insn_issue) state_d = ST_COUNT;
                ST_COUNT: if (cnt <= CNT_ONE) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        stalling = (state_q == ST_COUNT);
        dec      = stalling && !wr_hit && (cnt != '0) && run_ok;
        done     = dec && (cnt == CNT_ONE);
    end

    assert_count_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (cnt != '0));
    assert_armed_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !wr_hit && !insn_issue) |=> (state_q == ST_ARMED));
    assert_issue_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !wr_hit && insn_issue) |=> stalling);
endmodule

// File: rtl/halt_ctl_reg.sv
module halt_ctl_reg
    import halt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq,
    input  logic              dec,
    input  logic              done,
    output logic [DATA_W-1:0] ctl_q
);
    logic [DATA_W-1:0] ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_hit) begin
            ctl_d = wdata;
        end else begin
            if (irq) ctl_d[SLEEP_BIT] = 1'b0;
            if (dec) ctl_d[CNT_W-1:0] = ctl_q[CNT_W-1:0] - CNT_W'(1);
            if (done && ctl_q[WAIT_A_BIT]) ctl_d[WAIT_B_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assert_sleep_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[SLEEP_BIT] && !irq && !wr_hit) |=> ctl_q[SLEEP_BIT]);
    assert_irq_wakes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[SLEEP_BIT] && irq && !wr_hit) |=> !ctl_q[SLEEP_BIT]);
    assert_dec_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec |=> (ctl_q[CNT_W-1:0] == $past(ctl_q[CNT_W-1:0]) - CNT_W'(1)));
    assert_pair_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ctl_q[WAIT_A_BIT] && ctl_q[WAIT_B_BIT]) |=> (ctl_q[WAIT_A_BIT] && !ctl_q[WAIT_B_BIT]));
    assert_flags_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(ctl_q[WAIT_B_BIT-1:CNT_W]));
    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (ctl_q == $past(wdata)));
endmodule

// File: rtl/core_halt_ctl.sv
module core_halt_ctl
    import halt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              irq,
    input  logic              insn_issue,
    output logic              halt
);
    logic [DATA_W-1:0] ctl_q;
    logic wr_hit, arm_wr, run_ok, dec, done, stalling;

    always_comb begin
        wr_hit = sel && wr_en;
        arm_wr = wdata[START_BIT] && (wdata[WAIT_A_BIT] || wdata[WAIT_B_BIT])
                 && (wdata[CNT_W-1:0] != '0);
        run_ok = ctl_q[START_BIT] && (ctl_q[WAIT_A_BIT] || ctl_q[WAIT_B_BIT]);
        rdata  = sel ? ctl_q : '0;
        halt   = ctl_q[SLEEP_BIT] || stalling;
    end

    halt_ctl_reg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(wdata),
        .irq(irq), .dec(dec), .done(done), .ctl_q(ctl_q)
    );

    halt_cd_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .arm_wr(arm_wr),
        .insn_issue(insn_issue), .run_ok(run_ok), .cnt(ctl_q[CNT_W-1:0]),
        .dec(dec), .done(done), .stalling(stalling)
    );

    assert_zero_write_wakes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wdata == '0) |=> !halt);
    assert_idle_no_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !wr_hit && !insn_issue && !ctl_q[SLEEP_BIT]) |=> !halt);
endmodule

// File: tb/sim_core_halt_ctl.sv
`timescale 1ns/1ps
module sim_core_halt_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, wr_en = 1'b0, irq = 1'b0, insn_issue = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic halt;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] m_reg = '0;
    int m_st = 0;
    logic obs_halt;
    logic [31:0] obs_rdata;

    always #10 clk = ~clk;

    core_halt_ctl u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .irq(irq), .insn_issue(insn_issue), .halt(halt)
    );

    function automatic bit arms(input logic [31:0] w);
        return w[27] && (w[30] || w[29]) && (w[7:0] != 8'd0);
    endfunction

    function automatic logic exp_halt();
        return m_reg[31] || (m_st == 2);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step_model(input bit s, input bit w, input logic [31:0] d, input bit i, input bit iss);
        if (s && w) begin
            m_reg = d;
            m_st  = arms(d) ? 1 : 0;
        end else begin
            if (i) m_reg[31] = 1'b0;
            if (m_st == 1 && iss) m_st = 2;
            else if (m_st == 2) begin
                m_reg[7:0] = m_reg[7:0] - 8'd1;
                if (m_reg[7:0] == 8'd0) begin
                    if (m_reg[30]) m_reg[29] = 1'b0;
                    m_st = 0;
                end
            end
        end
    endtask

    task automatic cyc(input bit s, input bit w, input logic [31:0] d, input bit i, input bit iss, input string tag);
        @(negedge clk);
        sel = s; wr_en = w; wdata = d; irq = i; insn_issue = iss;
        #1;
        obs_halt = halt;
        obs_rdata = rdata;
        chk(halt == exp_halt(), {tag, " halt"}, {31'd0, halt}, {31'd0, exp_halt()});
        chk(rdata == (s ? m_reg : 32'd0), {tag, " rdata"}, rdata, s ? m_reg : 32'd0);
        @(posedge clk);
        step_model(s, w, d, i, iss);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 32'd0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset value
        cyc(1, 0, 0, 0, 0, "R1");
        chk(obs_rdata == 32'd0 && !obs_halt, "R1 reset", obs_rdata, 32'd0);

        // R11 deselected read
        cyc(1, 1, 32'h1234_5600, 0, 0, "R11");
        cyc(0, 0, 0, 0, 0, "R11");
        chk(obs_rdata == 32'd0, "R11 sel low", obs_rdata, 32'd0);

        // R6 / R5 worked example
        cyc(1, 1, 32'h6800_0080, 0, 0, "R6");
        idle(3, "R4");
        cyc(1, 0, 0, 0, 1, "R4");
        n = 0;
        for (int k = 0; k < 200; k++) begin
            cyc(1, 0, 0, 0, 0, "R5");
            if (obs_halt) n++;
        end
        chk(n == 128, "R5 stall length", n, 128);
        cyc(1, 0, 0, 0, 0, "R6");
        chk(obs_rdata == 32'h4800_0000, "R6 readback", obs_rdata, 32'h4800_0000);

        // R7 single wait bits
        cyc(1, 1, 32'h4800_0005, 0, 0, "R7");
        cyc(1, 0, 0, 0, 1, "R7");
        idle(8, "R7");
        chk(obs_rdata == 32'h4800_0000, "R7 bit30 only", obs_rdata, 32'h4800_0000);
        cyc(1, 1, 32'h2800_0003, 0, 0, "R7");
        cyc(1, 0, 0, 0, 1, "R7");
        idle(6, "R7");
        chk(obs_rdata == 32'h2800_0000, "R7 bit29 only", obs_rdata, 32'h2800_0000);

        // R8 non-arming writes
        cyc(1, 1, 32'h4000_0010, 0, 0, "R8");
        cyc(1, 0, 0, 0, 1, "R8");
        idle(3, "R8");
        chk(!obs_halt && obs_rdata == 32'h4000_0010, "R8 no start", obs_rdata, 32'h4000_0010);
        cyc(1, 1, 32'h0800_0010, 0, 0, "R8");
        cyc(1, 0, 0, 0, 1, "R8");
        idle(3, "R8");
        chk(!obs_halt && obs_rdata == 32'h0800_0010, "R8 no wait", obs_rdata, 32'h0800_0010);
        cyc(1, 1, 32'h6800_0000, 0, 0, "R8");
        cyc(1, 0, 0, 0, 1, "R8");
        idle(2, "R8");
        chk(!obs_halt, "R8 zero count", {31'd0, obs_halt}, 32'd0);

        // R9 flag storage
        cyc(1, 1, 32'h17FF_FF00, 0, 0, "R9");
        cyc(1, 0, 0, 0, 1, "R9");
        idle(2, "R9");
        chk(!obs_halt && obs_rdata == 32'h17FF_FF00, "R9 flags", obs_rdata, 32'h17FF_FF00);

        // R2 / R3 sleep and wake
        cyc(1, 1, 32'h8000_0000, 0, 0, "R2");
        idle(5, "R2");
        chk(obs_halt == 1'b1, "R2 asleep", {31'd0, obs_halt}, 32'd1);
        cyc(1, 0, 0, 1, 0, "R3");
        cyc(1, 0, 0, 0, 0, "R3");
        chk(obs_halt == 1'b0, "R3 woke", {31'd0, obs_halt}, 32'd0);

        // R10 write beats irq, zero write stops countdown
        cyc(1, 1, 32'h8000_0000, 0, 0, "R10");
        cyc(1, 1, 32'h8000_0000, 1, 0, "R10");
        cyc(1, 0, 0, 0, 0, "R10");
        chk(obs_halt == 1'b1, "R10 write over irq", {31'd0, obs_halt}, 32'd1);
        cyc(1, 1, 32'h4800_0040, 0, 0, "R10");
        cyc(1, 0, 0, 0, 1, "R10");
        idle(4, "R10");
        cyc(1, 1, 32'd0, 0, 0, "R10");
        cyc(1, 0, 0, 0, 0, "R10");
        chk(!obs_halt && obs_rdata == 32'd0, "R10 zero wake", obs_rdata, 32'd0);

        // Random mix, checked every cycle against the model (R2-R10)
        for (int k = 0; k < 6000; k++) begin
            bit s, w, i, iss;
            s = ($urandom % 8) != 0;
            w = ($urandom % 10) == 0;
            i = ($urandom % 12) == 0;
            iss = ($urandom % 4) == 0;
            v = $urandom;
            v[7:0] = 8'($urandom % 12);
            if (($urandom % 3) != 0) v[27] = 1'b1;
            if (($urandom % 5) != 0) v[31] = 1'b0;
            cyc(s, w, v, i, iss, "R5 random");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule